// File: doc/BRIEF.md
# Floating-point status register unit

This block keeps the 32-bit floating-point status and control word of a processor core. Each time an arithmetic operation finishes, the datapath hands it the current-exception vector for that result. The block merges the vector into the stored word and works out the three summary flags: new-exception, enabled-exception and invalid-operation. When an enabled exception is newly raised, it requests a trap.

The same block also runs the status-move operations. These are: a whole-word load under an 8-bit nibble mask, a 4-bit immediate written into one field, setting or clearing a single bit, and copying one status field into a field of a 32-bit condition register. Condition-register updates leave the block as a 4-bit nibble, a 3-bit field index and a one-cycle write strobe.

Operations arrive as a single-cycle `op_valid` pulse with their operands. The block accepts one operation every cycle and never applies back-pressure, so it has no ready signal. All outputs are registered and reflect an operation one clock after its pulse.

Top module: `fsr_unit`

## Requirements
- R1: A synchronous active-high reset clears the status word to 0 and holds `cr_we` and `trap_req` low.
- R2: For operations 0 (arith) and 1 (compare) with a non-zero vector, bit 31 is first cleared. It is then set if the vector and the stored word differ in any exception-class bit (bits 29..19 and 10..8). A zero vector leaves the word unchanged.
- R3: The enables at bits 7..3, shifted left by 22, line up with bits 29..25. If a vector bit meets an aligned enable, bit 30 is set and `trap_req` pulses for one cycle. A sticky bit 30 alone raises no trap.
- R4: Bit 29 is set when the vector has any invalid sub-cause bit. The sub-cause bits are 24..19 and 10..8.
- R5: When the vector has any result-flag bit (bits 16..12), the stored bits 16..12 are cleared before the vector is ORed in.
- R6: Operation 4 writes nibble i (bits 4i+3..4i) from `src_word` where `fmask[i]` is 1 and keeps the other nibbles. A mask of 8'hFF loads the whole word.
- R7: Operation 3 writes `imm4` at bit offset 28-4*`fld_dst` and leaves the other nibbles unchanged.
- R8: Operation 2 sends nibble `fld_src` of the status word (offset 28-4*field) to condition field `fld_dst` with `cr_we`. It then clears that nibble's sticky bits (31, 28..19, 10..8).
- R9: Operation 0 with `op_rec` high writes the new bits 31..28 to condition field 1. Without `op_rec` it raises no `cr_we`.
- R10: Operation 1 writes the new bits 15..12 to condition field `fld_dst`.
- R11: Operations 5 (set) and 6 (clear) act on bit 31-`bit_idx`.
- R12: Without `op_valid`, or with operation code 7, the word does not change and `cr_we` and `trap_req` stay low. Results appear one cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | One-cycle operation strobe |
| op_sel | input | 3 | Operation code (0..7) |
| op_rec | input | 1 | Record form for arith |
| exc_vec | input | 32 | Current-exception vector |
| fld_dst | input | 3 | Target field index |
| fld_src | input | 3 | Source status field index |
| imm4 | input | 4 | Field immediate |
| bit_idx | input | 5 | Bit number n for set/clear |
| fmask | input | 8 | Nibble write mask |
| src_word | input | 32 | Source word for masked load |
| fsr_q | output | 32 | Status word |
| cr_nib | output | 4 | Condition nibble |
| cr_fld | output | 3 | Condition field index |
| cr_we | output | 1 | Condition write strobe |
| trap_req | output | 1 | Trap request pulse |

## Verification
The bench repeats the same exception vector. A design that treated bit 31 as sticky, instead of clearing it first, would report a new exception a second time. It raises a second exception while bit 30 is already set; a design that traps on the sticky summary rather than on a new hit would trap wrongly. It loads stale result flags and a set bit 29 before a result vector, which exposes a design that ORs the flags without clearing them or computes bit 31 from the vector alone. Field moves at field 0, field 7 and bit numbers 0 and 31 catch a reversed nibble order, and the copy test shows whether non-sticky bits survive the clear.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int W        = 32;
  localparam int NIB_W    = 4;
  localparam int NFLD     = W / NIB_W;
  localparam int FLD_W    = $clog2(NFLD);
  localparam int BIT_W    = $clog2(W);
  localparam int EN_SHIFT = 22;

  localparam logic [W-1:0] NEW_BIT   = 32'h8000_0000;
  localparam logic [W-1:0] TRAP_BIT  = 32'h4000_0000;
  localparam logic [W-1:0] INV_BIT   = 32'h2000_0000;
  localparam logic [W-1:0] CLASS_MSK = 32'h3FF8_0700;
  localparam logic [W-1:0] SUB_MSK   = 32'h01F8_0700;
  localparam logic [W-1:0] STICKY    = 32'h9FF8_0700;
  localparam logic [W-1:0] RES_MSK   = 32'h0001_F000;
  localparam logic [W-1:0] EN_MSK    = 32'h0000_00F8;
  localparam int REC_FLD = 1;
  localparam int CC_LO   = 12;

  typedef enum logic [2:0] {
    OP_ARITH = 3'd0,
    OP_CMP   = 3'd1,
    OP_COPY  = 3'd2,
    OP_IMM   = 3'd3,
    OP_LOAD  = 3'd4,
    OP_BSET  = 3'd5,
    OP_BCLR  = 3'd6,
    OP_NONE  = 3'd7
  } op_e;
endpackage

// File: rtl/fsr_except_merge.sv
module fsr_except_merge
  import fsr_pkg::*;
(
  input  logic [W-1:0] cur,
  input  logic [W-1:0] cx,
  output logic [W-1:0] nxt,
  output logic         fex_hit
);
  logic [W-1:0] r;
  logic [W-1:0] en_al;

  always_comb begin
    r       = cur;
    en_al   = '0;
    fex_hit = 1'b0;
    if (cx != '0) begin
      r = r & ~NEW_BIT;
      if (((cx ^ r) & CLASS_MSK) != '0) r = r | NEW_BIT;
      en_al = (r & EN_MSK) << EN_SHIFT;
      if ((cx & en_al) != '0) begin
        r       = r | TRAP_BIT;
        fex_hit = 1'b1;
      end
      if ((cx & RES_MSK) != '0) r = r & ~RES_MSK;
      if ((cx & SUB_MSK) != '0) r = r | INV_BIT;
      r = r | cx;
    end
    nxt = r;
  end
endmodule

// File: rtl/fsr_field_mask.sv
module fsr_field_mask
  import fsr_pkg::*;
#(
  parameter int N_FLD = NFLD,
  parameter int FW    = NIB_W,
  localparam int TW   = N_FLD * FW
) (
  input  logic [N_FLD-1:0] fmask,
  output logic [TW-1:0]    wmask
);
  for (genvar i = 0; i < N_FLD; i++) begin : g_nib
    assign wmask[i*FW +: FW] = {FW{fmask[i]}};
  end
endmodule

// File: rtl/fsr_nib_pick.sv
module fsr_nib_pick
  import fsr_pkg::*;
(
  input  logic [W-1:0]     word,
  input  logic [FLD_W-1:0] fld,
  output logic [NIB_W-1:0] nib,
  output logic [W-1:0]     nmask,
  output logic [BIT_W-1:0] sh
);
  localparam logic [W-1:0] ONE_NIB = W'((1 << NIB_W) - 1);

  always_comb begin
    sh    = BIT_W'((NFLD - 1 - int'(fld)) * NIB_W);
    nib   = NIB_W'(word >> sh);
    nmask = ONE_NIB << sh;
  end
endmodule

// File: rtl/fsr_unit.sv
module fsr_unit
  import fsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [2:0]       op_sel,
  input  logic             op_rec,
  input  logic [31:0]      exc_vec,
  input  logic [2:0]       fld_dst,
  input  logic [2:0]       fld_src,
  input  logic [3:0]       imm4,
  input  logic [4:0]       bit_idx,
  input  logic [7:0]       fmask,
  input  logic [31:0]      src_word,
  output logic [31:0]      fsr_q,
  output logic [3:0]       cr_nib,
  output logic [2:0]       cr_fld,
  output logic             cr_we,
  output logic             trap_req
);
  logic [W-1:0]     merged;
  logic             fex_hit;
  logic [W-1:0]     load_wm;
  logic [NIB_W-1:0] src_nib;
  logic [W-1:0]     src_nmask;
  logic [BIT_W-1:0] src_sh;
  logic [NIB_W-1:0] dst_nib;
  logic [W-1:0]     dst_nmask;
  logic [BIT_W-1:0] dst_sh;

  logic [W-1:0]     fsr_d;
  logic [NIB_W-1:0] nib_d;
  logic [FLD_W-1:0] fld_d;
  logic             we_d;
  logic             trap_d;
  logic [BIT_W-1:0] bpos;

  fsr_except_merge u_merge (
    .cur     (fsr_q),
    .cx      (exc_vec),
    .nxt     (merged),
    .fex_hit (fex_hit)
  );

  fsr_field_mask #(.N_FLD(NFLD), .FW(NIB_W)) u_fmask (
    .fmask (fmask),
    .wmask (load_wm)
  );

  fsr_nib_pick u_src (
    .word  (fsr_q),
    .fld   (fld_src),
    .nib   (src_nib),
    .nmask (src_nmask),
    .sh    (src_sh)
  );

  fsr_nib_pick u_dst (
    .word  (fsr_q),
    .fld   (fld_dst),
    .nib   (dst_nib),
    .nmask (dst_nmask),
    .sh    (dst_sh)
  );

  always_comb begin
    fsr_d  = fsr_q;
    nib_d  = '0;
    fld_d  = '0;
    we_d   = 1'b0;
    trap_d = 1'b0;
    bpos   = BIT_W'(W - 1) - bit_idx;
    if (op_valid) begin
      case (op_e'(op_sel))
        OP_ARITH: begin
          fsr_d  = merged;
          trap_d = fex_hit;
          if (op_rec) begin
            we_d  = 1'b1;
            fld_d = FLD_W'(REC_FLD);
            nib_d = merged[W-1 -: NIB_W];
          end
        end
        OP_CMP: begin
          fsr_d  = merged;
          trap_d = fex_hit;
          we_d   = 1'b1;
          fld_d  = fld_dst;
          nib_d  = merged[CC_LO +: NIB_W];
        end
        OP_COPY: begin
          we_d  = 1'b1;
          fld_d = fld_dst;
          nib_d = src_nib;
          fsr_d = fsr_q & ~(src_nmask & STICKY);
        end
        OP_IMM:  fsr_d = (fsr_q & ~dst_nmask) | (W'(imm4) << dst_sh);
        OP_LOAD: fsr_d = (fsr_q & ~load_wm) | (src_word & load_wm);
        OP_BSET: fsr_d[bpos] = 1'b1;
        OP_BCLR: fsr_d[bpos] = 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsr_q    <= '0;
      cr_nib   <= '0;
      cr_fld   <= '0;
      cr_we    <= 1'b0;
      trap_req <= 1'b0;
    end else begin
      fsr_q    <= fsr_d;
      cr_nib   <= nib_d;
      cr_fld   <= fld_d;
      cr_we    <= we_d;
      trap_req <= trap_d;
    end
  end
endmodule

// File: rtl/fsr_unit_chk.sv
module fsr_unit_chk
  import fsr_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        op_valid,
  input logic [2:0]  op_sel,
  input logic        op_rec,
  input logic [31:0] exc_vec,
  input logic [2:0]  fld_dst,
  input logic [4:0]  bit_idx,
  input logic [31:0] fsr_q,
  input logic [3:0]  cr_nib,
  input logic [2:0]  cr_fld,
  input logic        cr_we,
  input logic        trap_req
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (fsr_q == 32'h0 && !cr_we && !trap_req));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> ($stable(fsr_q) && !cr_we && !trap_req));

  // R3
  trap_summary_chk: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> fsr_q[30]);

  // R4
  inv_summary_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == 3'd0 && (exc_vec & SUB_MSK) != 32'h0) |=> fsr_q[29]);

  // R9
  rec_route_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == 3'd0 && op_rec) |=>
      (cr_we && cr_fld == 3'd1 && cr_nib == fsr_q[31:28]));

  // R10
  cmp_route_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == 3'd1) |=>
      (cr_we && cr_fld == $past(fld_dst) && cr_nib == fsr_q[15:12]));

  // R11
  bit_set_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == 3'd5) |=> fsr_q[5'd31 - $past(bit_idx)]);
endmodule

bind fsr_unit fsr_unit_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_valid (op_valid),
  .op_sel   (op_sel),
  .op_rec   (op_rec),
  .exc_vec  (exc_vec),
  .fld_dst  (fld_dst),
  .bit_idx  (bit_idx),
  .fsr_q    (fsr_q),
  .cr_nib   (cr_nib),
  .cr_fld   (cr_fld),
  .cr_we    (cr_we),
  .trap_req (trap_req)
);

// File: tb/fsr_unit_test.sv
module fsr_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [2:0]  op_sel = '0;
  logic        op_rec = 1'b0;
  logic [31:0] exc_vec = '0;
  logic [2:0]  fld_dst = '0;
  logic [2:0]  fld_src = '0;
  logic [3:0]  imm4 = '0;
  logic [4:0]  bit_idx = '0;
  logic [7:0]  fmask = '0;
  logic [31:0] src_word = '0;
  logic [31:0] fsr_q;
  logic [3:0]  cr_nib;
  logic [2:0]  cr_fld;
  logic        cr_we;
  logic        trap_req;

  int n_run  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  fsr_unit uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] sel, input logic [31:0] vec = '0,
                       input logic rec = 1'b0);
    op_valid = 1'b1; op_sel = sel; exc_vec = vec; op_rec = rec;
    @(negedge clk);
    op_valid = 1'b0; exc_vec = '0; op_rec = 1'b0;
  endtask

  task automatic load(input logic [31:0] w, input logic [7:0] m = 8'hFF);
    src_word = w; fmask = m;
    issue(3'd4);
  endtask

  task automatic t_reset;
    chk("R1 fsr", fsr_q, 32'h0);
    chk("R1 cr_we", {31'h0, cr_we}, 32'h0);
    chk("R1 trap", {31'h0, trap_req}, 32'h0);
  endtask

  task automatic t_load;
    load(32'h1234_5678);
    chk("R6 full", fsr_q, 32'h1234_5678);
    load(32'hABCD_EF01, 8'h81);
    chk("R6 masked", fsr_q, 32'hA234_5671);
  endtask

  task automatic t_imm;
    fld_dst = 3'd2; imm4 = 4'h9; issue(3'd3);
    chk("R7 field2", fsr_q, 32'hA294_5671);
    fld_dst = 3'd7; imm4 = 4'hC; issue(3'd3);
    chk("R7 field7", fsr_q, 32'hA294_567C);
  endtask

  task automatic t_bits;
    load(32'h0);
    bit_idx = 5'd0; issue(3'd5);
    chk("R11 set0", fsr_q, 32'h8000_0000);
    bit_idx = 5'd31; issue(3'd5);
    chk("R11 set31", fsr_q, 32'h8000_0001);
    bit_idx = 5'd0; issue(3'd6);
    chk("R11 clr0", fsr_q, 32'h0000_0001);
  endtask

  task automatic t_new_exc;
    load(32'h0);
    issue(3'd0, 32'h1000_0000);
    chk("R2 first", fsr_q, 32'h9000_0000);
    chk("R2 no trap", {31'h0, trap_req}, 32'h0);
    chk("R9 no rec", {31'h0, cr_we}, 32'h0);
    issue(3'd0, 32'h1000_0000);
    chk("R2 repeat", fsr_q, 32'h1000_0000);
    issue(3'd0, 32'h0);
    chk("R2 zero vec", fsr_q, 32'h1000_0000);
  endtask

  task automatic t_enabled;
    load(32'h0000_0010);
    issue(3'd0, 32'h0400_0000);
    chk("R3 hit", fsr_q, 32'hC400_0010);
    chk("R3 trap", {31'h0, trap_req}, 32'h1);
    issue(3'd0, 32'h0800_0000);
    chk("R3 sticky", fsr_q, 32'hCC00_0010);
    chk("R3 no retrap", {31'h0, trap_req}, 32'h0);
  endtask

  task automatic t_invalid;
    load(32'h0);
    issue(3'd0, 32'h0020_0000);
    chk("R4 zdz", fsr_q, 32'hA020_0000);
    load(32'h0);
    issue(3'd0, 32'h0000_0200);
    chk("R4 sqrt", fsr_q, 32'hA000_0200);
  endtask

  task automatic t_result;
    load(32'h2001_A000);
    issue(3'd0, 32'h0000_4000, 1'b1);
    chk("R5 flags", fsr_q, 32'hA000_4000);
    chk("R9 we", {31'h0, cr_we}, 32'h1);
    chk("R9 fld", {29'h0, cr_fld}, 32'h1);
    chk("R9 nib", {28'h0, cr_nib}, 32'hA);
  endtask

  task automatic t_cmp;
    load(32'h0);
    fld_dst = 3'd6;
    issue(3'd1, 32'h0000_2000);
    chk("R10 fsr", fsr_q, 32'h0000_2000);
    chk("R10 we", {31'h0, cr_we}, 32'h1);
    chk("R10 fld", {29'h0, cr_fld}, 32'h6);
    chk("R10 nib", {28'h0, cr_nib}, 32'h2);
  endtask

  task automatic t_copy;
    load(32'hFFFF_FFFF);
    fld_src = 3'd0; fld_dst = 3'd5; issue(3'd2);
    chk("R8 clr f0", fsr_q, 32'h6FFF_FFFF);
    chk("R8 nib", {28'h0, cr_nib}, 32'hF);
    chk("R8 fld", {29'h0, cr_fld}, 32'h5);
    chk("R8 we", {31'h0, cr_we}, 32'h1);
    fld_src = 3'd3; fld_dst = 3'd0; issue(3'd2);
    chk("R8 clr f3", fsr_q, 32'h6FF7_FFFF);
    chk("R8 fld0", {29'h0, cr_fld}, 32'h0);
  endtask

  task automatic t_idle;
    load(32'h1357_9BDF);
    repeat (3) @(negedge clk);
    chk("R12 hold", fsr_q, 32'h1357_9BDF);
    chk("R12 no we", {31'h0, cr_we}, 32'h0);
    src_word = 32'h0; fmask = 8'hFF;
    issue(3'd7, 32'hFFFF_FFFF);
    chk("R12 code7", fsr_q, 32'h1357_9BDF);
    chk("R12 code7 trap", {31'h0, trap_req}, 32'h0);
    op_sel = 3'd4; exc_vec = 32'h1000_0000;
    @(negedge clk);
    chk("R12 no valid", fsr_q, 32'h1357_9BDF);
    exc_vec = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_load();
    t_imm();
    t_bits();
    t_new_exc();
    t_enabled();
    t_invalid();
    t_result();
    t_cmp();
    t_copy();
    t_idle();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule